// File: doc/BRIEF.md
# Segmented Memory-Operand Address Generator

This block turns the operand fields of a memory-referencing instruction into a bus address. It receives an addressing-mode code, selectors that pick which base, index or pointer registers take part, a displacement that may be 8 or 16 bits wide, the current values of the four pointer/index registers and the four segment registers, and an optional segment override. From these it forms a 16-bit offset within a segment, selects a segment, and joins the two into a 20-bit physical address.

The offset is always reduced to 16 bits, so every operand stays inside a 64 KB window. The physical address is the segment value shifted left by four bits plus the offset, reduced modulo 1 MB, so a window that crosses the top of the space continues at address zero. When no override is given, the segment is chosen from the registers in use: the stack segment when the base pointer forms part of the address, otherwise the data segment.

The generator is a two-stage pipeline. A request presented with `in_valid` high yields its result with `out_valid` high two clock edges later, and results hold between requests.

Top module: `seg_addr_gen`

## Requirements
- R1: Mode code 0 (direct) gives an offset equal to the full 16-bit `disp`, whatever `disp_wide` says, with the data segment as default.
- R2: Mode code 1 (register indirect) gives an offset of SI when `ind_sel`=0, DI when 1, and BX when 2 or 3; no displacement is added and the default segment is the data segment.
- R3: Mode code 2 (based relative) gives an offset of the base register (BX when `base_sel`=0, BP when 1) plus the extended displacement.
- R4: Mode code 3 (indexed relative) gives an offset of the index register (SI when `idx_sel`=0, DI when 1) plus the extended displacement, with the data segment as default.
- R5: Mode code 4 (based indexed) gives an offset of base register plus index register plus the extended displacement, using the same selector meanings as R3 and R4.
- R6: Without an override, the segment is the stack segment (code 1) when `base_sel`=1 in mode 2 or 4, and the data segment (code 0) in every other case; segment codes are 0 data, 1 stack, 2 extra, 3 code.
- R7: When `ovr_en` is 1, `out_seg` equals `ovr_seg` and the physical address uses that segment's value, whatever the mode.
- R8: The offset is the sum modulo 2^16, and `out_phys` equals (segment value × 16 + offset) modulo 2^20, so its low four bits equal the offset's low four bits.
- R9: When `disp_wide`=0, modes 2, 3 and 4 use `disp[7:0]` sign-extended to 16 bits; when `disp_wide`=1 they use all 16 bits of `disp`.
- R10: A request with `in_valid`=1 at one rising edge appears with `out_valid`=1 after the second rising edge; `out_valid` is 0 otherwise and the other outputs keep their values while no result arrives.
- R11: Mode codes 5, 6 and 7 behave exactly as the direct mode of R1.
- R12: After synchronous reset `out_valid`, `out_seg`, `out_off` and `out_phys` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| base_sel | input | 1 | Base register choice: 0 BX, 1 BP |
| idx_sel | input | 1 | Index register choice: 0 SI, 1 DI |
| ind_sel | input | 2 | Register-indirect choice: 0 SI, 1 DI, 2/3 BX |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit sign-extended |
| disp | input | 16 | Displacement from the instruction |
| reg_bx | input | 16 | Base register BX value |
| reg_bp | input | 16 | Base pointer BP value |
| reg_si | input | 16 | Source index SI value |
| reg_di | input | 16 | Destination index DI value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| ovr_en | input | 1 | Segment override active |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result strobe |
| out_seg | output | 2 | Chosen segment code |
| out_off | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
On every cycle the assertions check the two-cycle strobe timing and the holding of outputs between results, that the direct mode passes the displacement through, that an override always wins, that a base-pointer operand without override lands in the stack segment, and that the physical address keeps the offset's low nibble. The full arithmetic of each mode, the sign extension of short displacements, and the wrap of both the offset and the physical address are shown only by the bench's sweep, which runs every mode and selector combination over register sets placed near the 64 KB and 1 MB boundaries and compares against values it computes itself.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT      = 3'd0,
    AM_REG_IND     = 3'd1,
    AM_BASED_REL   = 3'd2,
    AM_INDEXED_REL = 3'd3,
    AM_BASED_IDX   = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_CODE  = 2'd3
  } seg_e;

  // Register-indirect selector codes
  localparam logic [1:0] IND_SI = 2'd0;
  localparam logic [1:0] IND_DI = 2'd1;

endpackage

// File: rtl/sag_offset_calc.sv
module sag_offset_calc
  import sag_pkg::*;
#(
  parameter int OFF_W    = 16,
  parameter int NARROW_W = 8
) (
  input  amode_e             mode,
  input  logic               base_sel,
  input  logic               idx_sel,
  input  logic [1:0]         ind_sel,
  input  logic               disp_wide,
  input  logic [OFF_W-1:0]   disp,
  input  logic [OFF_W-1:0]   bx,
  input  logic [OFF_W-1:0]   bp,
  input  logic [OFF_W-1:0]   si,
  input  logic [OFF_W-1:0]   di,
  output logic [OFF_W-1:0]   off,
  output logic               bp_used
);

  localparam int EXT_W = OFF_W - NARROW_W;

  logic [OFF_W-1:0] base_v;
  logic [OFF_W-1:0] idx_v;
  logic [OFF_W-1:0] ind_v;
  logic [OFF_W-1:0] disp_x;

  // short displacements are sign-extended to the offset width
  generate
    if (EXT_W > 0) begin : g_ext
      always_comb begin
        if (disp_wide) disp_x = disp;
        else           disp_x = {{EXT_W{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};
      end
    end else begin : g_noext
      always_comb disp_x = disp;
    end
  endgenerate

  always_comb begin
    base_v = base_sel ? bp : bx;
    idx_v  = idx_sel  ? di : si;
    case (ind_sel)
      IND_SI:  ind_v = si;
      IND_DI:  ind_v = di;
      default: ind_v = bx;
    endcase
  end

  // sums wrap naturally at OFF_W bits
  always_comb begin
    case (mode)
      AM_REG_IND:     off = ind_v;
      AM_BASED_REL:   off = base_v + disp_x;
      AM_INDEXED_REL: off = idx_v + disp_x;
      AM_BASED_IDX:   off = base_v + idx_v + disp_x;
      default:        off = disp;
    endcase
  end

  assign bp_used = base_sel && ((mode == AM_BASED_REL) || (mode == AM_BASED_IDX));

endmodule

// File: rtl/sag_seg_pick.sv
module sag_seg_pick
  import sag_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             bp_used,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic [SEG_W-1:0] seg_ds,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  output seg_e             seg_id,
  output logic [SEG_W-1:0] seg_val
);

  always_comb begin
    if (ovr_en)       seg_id = seg_e'(ovr_seg);
    else if (bp_used) seg_id = SEG_STACK;
    else              seg_id = SEG_DATA;
  end

  always_comb begin
    case (seg_id)
      SEG_STACK: seg_val = seg_ss;
      SEG_EXTRA: seg_val = seg_es;
      SEG_CODE:  seg_val = seg_cs;
      default:   seg_val = seg_ds;
    endcase
  end

endmodule

// File: rtl/sag_phys_join.sv
module sag_phys_join #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  off,
  output logic [PHYS_W-1:0] phys
);

  logic [PHYS_W-1:0] seg_base;
  logic [PHYS_W-1:0] off_ext;

  assign seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
  assign off_ext  = PHYS_W'(off);
  // carry out of the top bit is dropped: wrap at 2^PHYS_W
  assign phys     = seg_base + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import sag_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int NARROW_W  = 8,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic              base_sel,
  input  logic              idx_sel,
  input  logic [1:0]        ind_sel,
  input  logic              disp_wide,
  input  logic [OFF_W-1:0]  disp,
  input  logic [OFF_W-1:0]  reg_bx,
  input  logic [OFF_W-1:0]  reg_bp,
  input  logic [OFF_W-1:0]  reg_si,
  input  logic [OFF_W-1:0]  reg_di,
  input  logic [SEG_W-1:0]  seg_ds,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_seg,
  output logic              out_valid,
  output logic [1:0]        out_seg,
  output logic [OFF_W-1:0]  out_off,
  output logic [PHYS_W-1:0] out_phys
);

  // ---------------- stage 0: combinational operand evaluation
  logic [OFF_W-1:0] c_off;
  logic             c_bp_used;
  seg_e             c_seg_id;
  logic [SEG_W-1:0] c_seg_val;

  sag_offset_calc #(.OFF_W(OFF_W), .NARROW_W(NARROW_W)) u_off (
    .mode      (amode_e'(mode)),
    .base_sel  (base_sel),
    .idx_sel   (idx_sel),
    .ind_sel   (ind_sel),
    .disp_wide (disp_wide),
    .disp      (disp),
    .bx        (reg_bx),
    .bp        (reg_bp),
    .si        (reg_si),
    .di        (reg_di),
    .off       (c_off),
    .bp_used   (c_bp_used)
  );

  sag_seg_pick #(.SEG_W(SEG_W)) u_seg (
    .bp_used (c_bp_used),
    .ovr_en  (ovr_en),
    .ovr_seg (ovr_seg),
    .seg_ds  (seg_ds),
    .seg_ss  (seg_ss),
    .seg_es  (seg_es),
    .seg_cs  (seg_cs),
    .seg_id  (c_seg_id),
    .seg_val (c_seg_val)
  );

  // ---------------- stage 1 registers
  logic             s1_valid;
  seg_e             s1_seg;
  logic [SEG_W-1:0] s1_seg_val;
  logic [OFF_W-1:0] s1_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_seg     <= SEG_DATA;
      s1_seg_val <= '0;
      s1_off     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_seg     <= c_seg_id;
        s1_seg_val <= c_seg_val;
        s1_off     <= c_off;
      end
    end
  end

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 3'd0)) |=> (s1_off == $past(disp))); // R1
  AST_OVR_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_en) |=> (s1_seg == seg_e'($past(ovr_seg)))); // R7
  AST_BP_STACK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ovr_en && base_sel && ((mode == 3'd2) || (mode == 3'd4)))
      |=> (s1_seg == SEG_STACK)); // R6

  // ---------------- stage 2: physical address join and output registers
  logic [PHYS_W-1:0] c_phys;

  sag_phys_join #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_join (
    .seg_val (s1_seg_val),
    .off     (s1_off),
    .phys    (c_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_seg   <= 2'd0;
      out_off   <= '0;
      out_phys  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_seg  <= s1_seg;
        out_off  <= s1_off;
        out_phys <= c_phys;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R10
  AST_NO_SPUR: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_phys) && $stable(out_off) && $stable(out_seg))); // R10
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_phys[SEG_SHIFT-1:0] == out_off[SEG_SHIFT-1:0])); // R8

endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  mode;
  logic        base_sel, idx_sel, disp_wide, ovr_en;
  logic [1:0]  ind_sel, ovr_seg;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_ds, seg_ss, seg_es, seg_cs;
  logic        out_valid;
  logic [1:0]  out_seg;
  logic [15:0] out_off;
  logic [19:0] out_phys;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .base_sel(base_sel), .idx_sel(idx_sel), .ind_sel(ind_sel),
    .disp_wide(disp_wide), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es), .seg_cs(seg_cs),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .out_seg(out_seg), .out_off(out_off), .out_phys(out_phys)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent arithmetic model
  function automatic int model_off(int m, int bs, int is, int ids, int dw, int d,
                                   int bx, int bp, int si, int di);
    int dx, b, x, r;
    dx = dw ? d : ((d & 8'h80) ? ((d & 8'hFF) - 256) : (d & 8'hFF));
    b  = bs ? bp : bx;
    x  = is ? di : si;
    case (m)
      1: r = (ids == 0) ? si : ((ids == 1) ? di : bx);
      2: r = b + dx;
      3: r = x + dx;
      4: r = b + x + dx;
      default: r = d;
    endcase
    return r & 16'hFFFF;
  endfunction

  task automatic run_one(input int m, input int bs, input int is, input int ids,
                         input int dw, input int oe, input int os);
    int e_off, e_seg, e_sv;
    string t_off;
    @(negedge clk);
    in_valid = 1'b1; mode = 3'(m); base_sel = bs[0]; idx_sel = is[0];
    ind_sel = 2'(ids); disp_wide = dw[0]; ovr_en = oe[0]; ovr_seg = 2'(os);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    e_off = model_off(m, bs, is, ids, dw, int'(disp), int'(reg_bx), int'(reg_bp),
                      int'(reg_si), int'(reg_di));
    if (oe != 0) e_seg = os;
    else if (bs != 0 && (m == 2 || m == 4)) e_seg = 1;
    else e_seg = 0;
    case (e_seg)
      0: e_sv = int'(seg_ds);
      1: e_sv = int'(seg_ss);
      2: e_sv = int'(seg_es);
      default: e_sv = int'(seg_cs);
    endcase
    case (m)
      0: t_off = "R1 direct offset";
      1: t_off = "R2 indirect offset";
      2: t_off = (dw != 0) ? "R3 based offset" : "R9 short disp based";
      3: t_off = (dw != 0) ? "R4 indexed offset" : "R9 short disp indexed";
      4: t_off = (dw != 0) ? "R5 based-indexed offset" : "R9 short disp based-indexed";
      default: t_off = "R11 reserved mode as direct";
    endcase
    check("R10 out_valid", 32'(out_valid), 32'd1);
    check(t_off, 32'(out_off), 32'(e_off));
    check((oe != 0) ? "R7 override seg" : "R6 default seg", 32'(out_seg), 32'(e_seg));
    check("R8 physical", 32'(out_phys), 32'(((e_sv * 16) + e_off) & 32'hFFFFF));
  endtask

  task automatic load_regs(input int set);
    case (set)
      0: begin reg_bx = 16'h1234; reg_bp = 16'hFF00; reg_si = 16'h0F0F; reg_di = 16'h8001;
               seg_ds = 16'h2500; seg_ss = 16'hFF59; seg_es = 16'h0040; seg_cs = 16'hF000; end
      default: begin reg_bx = 16'hFFFF; reg_bp = 16'hFFFE; reg_si = 16'h8000; reg_di = 16'h7FFF;
               seg_ds = 16'hFFFF; seg_ss = 16'h0000; seg_es = 16'hABCD; seg_cs = 16'hFFF1; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] held_phys;
    logic [15:0] held_off;
    rst = 1'b1; in_valid = 1'b0; mode = '0; base_sel = 0; idx_sel = 0; ind_sel = '0;
    disp_wide = 0; disp = '0; ovr_en = 0; ovr_seg = '0;
    load_regs(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 reset out_valid", 32'(out_valid), 32'd0);
    check("R12 reset out_seg", 32'(out_seg), 32'd0);
    check("R12 reset out_off", 32'(out_off), 32'd0);
    check("R12 reset out_phys", 32'(out_phys), 32'd0);

    // exhaustive sweep of modes and selectors over register sets and displacements
    for (int set = 0; set < 2; set++) begin
      load_regs(set);
      for (int dsel = 0; dsel < 3; dsel++) begin
        disp = (dsel == 0) ? 16'h0080 : ((dsel == 1) ? 16'h7F7F : 16'hFF01);
        for (int m = 0; m < 8; m++)
          for (int bs = 0; bs < 2; bs++)
            for (int is = 0; is < 2; is++)
              for (int ids = 0; ids < 4; ids++)
                for (int dw = 0; dw < 2; dw++)
                  for (int oe = 0; oe < 2; oe++)
                    for (int os = 0; os < 4; os++)
                      if (oe != 0 || os == 0) run_one(m, bs, is, ids, dw, oe, os);
      end
    end

    // R8 physical wrap corner: segment FF59, offset FFFF -> 0F58F
    load_regs(0);
    disp = 16'hFFFF;
    run_one(0, 0, 0, 0, 1, 1, 1);
    check("R8 wrap corner", 32'(out_phys), 32'h0F58F);

    // R10 outputs hold while no request arrives, even as inputs change
    held_phys = out_phys; held_off = out_off;
    @(negedge clk);
    disp = 16'h0001; mode = 3'd4; seg_ss = 16'h1111; reg_bx = 16'h0; ovr_en = 0;
    repeat (3) @(negedge clk);
    check("R10 idle out_valid", 32'(out_valid), 32'd0);
    check("R10 hold out_phys", 32'(out_phys), 32'(held_phys));
    check("R10 hold out_off", 32'(out_off), 32'(held_off));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule